// File: doc/BRIEF.md
# Full-Array Pixel Record Serializer

After the conversion phase of a readout chip, this block sends out the complete stored contents of the pixel array on one serial data line. Each pixel holds four sample slots. Each slot holds one 25-bit record: a 12-bit amplitude, a 12-bit time stamp and a 1-bit gain-range flag. No zero suppression takes place. Every slot of every pixel goes into the frame, so the frame length is fixed and known in advance. At the default 1024 pixels, one frame is 102,400 bits, about 12.8 KB.

A one-cycle read command starts a frame. The block then walks the record store through a plain read-address port. The store returns data one cycle after it sees an address. A frame strobe stays high while record bits are on the line. A one-cycle done pulse follows the last bit. One bit leaves per clock cycle, so the clock frequency sets the line rate. At a 20 MHz bit clock, a full frame takes about 5.12 ms.

Top module: `pix_frame_ser`

## Requirements
- R1: While reset is asserted and after it is released, `frame_o`, `done_o` and `ser_o` are 0 and `rd_addr_o` is 0. `ser_o` is 0 whenever `frame_o` is low.
- R2: The block is idle when no frame is in progress. If `start_i` is high at a clock edge while the block is idle, `rd_addr_o` is 0 for the next two cycles with `frame_o` low. `frame_o` then rises in the third cycle after that edge.
- R3: `frame_o` stays high for exactly PIXELS*4*25 consecutive cycles. Every record is sent, including records whose bits are all zero.
- R4: Each record is sent as 25 consecutive bits on `ser_o`. The order is record word bit 24 down to bit 0: the amplitude occupies bits 24:13 and goes MSB first, the time stamp occupies bits 12:1 and goes MSB first, and the range flag is bit 0 and goes last.
- R5: Records are sent in ascending read-address order, where the address equals pixel*4 + slot. Slots 0 to 3 of a pixel therefore go out before the next pixel.
- R6: During bits 0 to 22 of record k, `rd_addr_o` equals k. During bits 23 and 24, it already equals k+1 (for the last record it stays at k). With the one-cycle store latency, this places the data of the next record at the port one bit-time before its first bit is sent.
- R7: `done_o` is high for exactly one cycle, the first cycle after the last bit, in which `frame_o` is already low.
- R8: `start_i` has no effect while a frame is being prepared or sent. The output bit stream and `rd_addr_o` continue unchanged.
- R9: A `start_i` sampled in the cycle where `done_o` is high starts a new frame with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read command, sampled while idle |
| rd_addr_o | output | $clog2(PIXELS*4) | Record store read address (pixel*4+slot) |
| rd_data_i | input | 25 | Record word, valid one cycle after its address |
| ser_o | output | 1 | Serial data, one bit per cycle |
| frame_o | output | 1 | High while record bits are on `ser_o` |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench builds the block with PIXELS=8, giving 32 records and an 800-bit frame. At that size, every frame can be compared bit by bit and address by address. Both ends of the record walk, including the held address on the last record, come up in each of several store fill patterns. The small size also makes it affordable to run back-to-back frames, start commands injected while busy, and a reset in the middle of a frame. The default 1024-pixel build is only elaborated. Nothing in the logic depends on the pixel count except counter widths and the last-record compare.

// File: rtl/pix_frame_pkg.sv
package pix_frame_pkg;
  localparam int AMP_W  = 12;
  localparam int TIME_W = 12;
  localparam int SLOTS  = 4;
  localparam int REC_W  = AMP_W + TIME_W + 1;

  // Field placement inside the stored word: the serializer sends bit REC_W-1 first.
  typedef struct packed {
    logic [AMP_W-1:0]  amp;
    logic [TIME_W-1:0] tstamp;
    logic              rng;
  } rec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_FETCH = 2'd2,
    ST_SHIFT = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pix_rec_shifter.sv
module pix_rec_shifter #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = din_i;
    else if (shift_i) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sh_q <= '0;
    else if (load_i || shift_i) sh_q <= sh_d;
  end

  assign msb_o = sh_q[W-1];

  // R4: a load or shift must never be requested together
  p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));
endmodule

// File: rtl/pix_frame_seq.sv
module pix_frame_seq
  import pix_frame_pkg::*;
#(
  parameter int PIXELS = 1024
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  output logic [$clog2(PIXELS*SLOTS)-1:0]     rd_addr_o,
  output logic                                load_o,
  output logic                                shift_o,
  output logic                                frame_o,
  output logic                                done_o
);
  localparam int TOTAL  = PIXELS * SLOTS;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam int BIT_W  = $clog2(REC_W);
  localparam int FBITS  = TOTAL * REC_W;
  localparam int LEN_W  = $clog2(FBITS + 1);
  localparam logic [ADDR_W-1:0] LAST_REC = ADDR_W'(TOTAL - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(REC_W - 1);
  localparam logic [BIT_W-1:0]  LEAD_BIT = BIT_W'(REC_W - 3);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] rec_q, rec_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;

  always_comb begin
    st_d    = st_q;
    rec_d   = rec_q;
    addr_d  = addr_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_ADDR;
        addr_d = '0;
      end
      ST_ADDR:  st_d = ST_FETCH;
      ST_FETCH: begin
        st_d   = ST_SHIFT;
        load_o = 1'b1;
        bit_d  = '0;
        rec_d  = '0;
      end
      ST_SHIFT: begin
        if (bit_q == LAST_BIT) begin
          if (rec_q == LAST_REC) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            load_o = 1'b1;
            bit_d  = '0;
            rec_d  = rec_q + 1'b1;
          end
        end else begin
          shift_o = 1'b1;
          bit_d   = bit_q + 1'b1;
          if (bit_q == LEAD_BIT && rec_q != LAST_REC) addr_d = rec_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rec_q  <= '0;
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rec_q  <= rec_d;
      addr_q <= addr_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign rd_addr_o = addr_q;
  assign frame_o   = (st_q == ST_SHIFT);
  assign done_o    = done_q;

  // Checker-only cycle count of the strobe window
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 len_q <= '0;
    else if (st_q == ST_FETCH)  len_q <= '0;
    else if (st_q == ST_SHIFT)  len_q <= len_q + 1'b1;
  end

  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> len_q == LEN_W'(FBITS));
  p_done_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!frame_o && $past(frame_o)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_o != $past(rd_addr_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1 || rd_addr_o == '0));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o && start_i) |=> (frame_o || done_o));
endmodule

// File: rtl/pix_frame_ser.sv
module pix_frame_ser
  import pix_frame_pkg::*;
#(
  parameter int PIXELS = 1024
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  output logic [$clog2(PIXELS*SLOTS)-1:0] rd_addr_o,
  input  logic [REC_W-1:0]                rd_data_i,
  output logic                            ser_o,
  output logic                            frame_o,
  output logic                            done_o
);
  logic load, shift, msb;

  pix_frame_seq #(.PIXELS(PIXELS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_addr_o (rd_addr_o),
    .load_o    (load),
    .shift_o   (shift),
    .frame_o   (frame_o),
    .done_o    (done_o)
  );

  pix_rec_shifter #(.W(REC_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .shift_i (shift),
    .din_i   (rd_data_i),
    .msb_o   (msb)
  );

  assign ser_o = msb & frame_o;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_o |-> !ser_o);
  p_start_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> (rd_addr_o == '0));
endmodule

// File: tb/pix_frame_ser_tb.sv
module pix_frame_ser_tb;
  localparam int PIX   = 8;
  localparam int TOT   = PIX * 4;
  localparam int AW    = $clog2(TOT);
  localparam int FBITS = TOT * 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [24:0]   rd_data;
  logic          ser, frame, done;
  logic [24:0]   mem [TOT];

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  pix_frame_ser #(.PIXELS(PIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .ser_o(ser), .frame_o(frame), .done_o(done)
  );

  always @(posedge clk) rd_data <= mem[rd_addr];

  // {pattern[1:0], inject start while busy, back-to-back with previous}
  localparam logic [3:0] VEC [6] = '{4'b00_0_0, 4'b01_1_0, 4'b10_0_1,
                                     4'b11_1_0, 4'b10_1_1, 4'b00_0_1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [24:0] pat(input int sel, input int i);
    case (sel)
      0: pat = '0;
      1: pat = '1;
      2: pat = {12'(i * 37 + 1), 12'(4095 - i * 5), i[0]};
      default: pat = 25'h0AAAAAA ^ 25'(i * 131);
    endcase
  endfunction

  task automatic fill(input int sel);
    for (int i = 0; i < TOT; i++) mem[i] = pat(sel, i);
  endtask

  // Called at the falling edge right after the edge that sampled start.
  task automatic frame_body(input bit inject);
    int bad_bit = 0, bad_addr = 0, bad_strb = 0;
    chk(!frame && !done && rd_addr == 0, "R2 prime1", int'(frame), 0);
    if (inject) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!frame && rd_addr == 0, "R2 prime2", int'(rd_addr), 0);
    @(negedge clk);
    for (int p = 0; p < FBITS; p++) begin
      int k = p / 25;
      int b = p % 25;
      int ea = (b >= 23 && k < TOT - 1) ? k + 1 : k;
      if (!frame) bad_strb++;
      if (ser !== mem[k][24 - b]) bad_bit++;
      if (rd_addr !== AW'(ea)) bad_addr++;
      start = (inject && (p == 137 || p == FBITS - 1)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(bad_strb == 0, "R3 strobe held", bad_strb, 0);
    chk(bad_bit == 0, "R4/R5 bit stream", bad_bit, 0);
    chk(bad_addr == 0, "R6 address lead", bad_addr, 0);
    chk(!frame && done, "R7 done after last bit", int'(done), 1);
    if (inject) chk(1'b1, "R8 busy start ignored (stream above)", 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!ended) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    fill(0);
    #1;
    chk(!frame && !done && !ser && rd_addr == 0, "R1 in reset", int'(frame), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!frame && !done && !ser && rd_addr == 0, "R1 after reset", int'(rd_addr), 0);
    repeat (5) @(negedge clk);
    chk(!frame && !done, "R2 idle without start", int'(frame), 0);

    for (int v = 0; v < 6; v++) begin
      logic [3:0] e = VEC[v];
      fill(int'(e[3:2]));
      if (e[0] && v > 0) begin
        start = 1'b1;                 // done cycle: R9
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R9 restart from done cycle", int'(done), 0);
      end else begin
        @(negedge clk);
        chk(!done && !frame, "R7 single done pulse", int'(done), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      frame_body(e[1]);
    end

    // Reset in the middle of a frame returns everything to R1 values
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk(frame, "R3 mid frame", int'(frame), 1);
    rst_n = 1'b0;
    #1;
    chk(!frame && !done && !ser && rd_addr == 0, "R1 reset mid frame", int'(rd_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!frame, "R1 stays idle after reset", int'(frame), 0);

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule